// File: doc/BRIEF.md
# Two-Channel Drive Command Mailbox

This block sits between a host processor and a slow command engine. It presents a small byte-wide register window. Before issuing a command, the host stages its argument bytes by writing them one at a time to a parameter port. It then writes the command number to the channel's command register, and that write launches the command. While the command runs, the host polls a status byte. When the command has finished, the host collects the answer by reading a result port repeatedly, and each read removes one byte.

Two channels with identical structure, called N and S, share the register window. Each channel has its own parameter store, result queue, busy flag and executor. A channel's parameter port and its status byte share one address: a write pushes a parameter byte and a read returns the status. A built-in executor stub stands in for the real engine, so the block can be exercised on its own. After a fixed delay it returns the parameter checksum followed by the command number.

Top module: `cmd_mailbox`

## Requirements
- R1: A write to a channel's command offset (N: 0x04, S: 0x16) while that channel is idle starts a command, and status bit 7 (busy) reads 1 from the next cycle.
- R2: A write to a channel's parameter/status offset (N: 0x05, S: 0x17) appends the byte to that channel's parameter store. A read of that offset returns the status: bit 7 is busy, bit 6 is 1 when the result queue is empty, and bits 5..0 are 0.
- R3: Each parameter store holds 16 bytes. A push while it is full is dropped and does not count toward the checksum.
- R4: Busy stays set for exactly 8 cycles after the command write. The result queue then holds two bytes in this order: the sum of the accepted parameter bytes modulo 256, then the command number.
- R5: Each read of a channel's result offset (N: 0x08, S: 0x18) returns and removes the oldest result byte. A read from an empty queue returns 0x00.
- R6: Accepting a command clears that channel's result queue and its parameter store, so the next command's checksum covers only bytes pushed after this acceptance.
- R7: A command write while the channel is busy is ignored. The running command's results are unchanged and no second execution follows.
- R8: The two channels are independent. Activity on one never changes the other's status or results.
- R9: After reset both channels read status 0x40. Reads of offsets outside the six mapped ones return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; pops the result queue when the result offset is selected |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |

## Verification
The bench builds the block with its default settings: 16-byte stores and an 8-cycle executor. With these settings, a run of 17 or more pushes reaches the full-store drop. The short execution window also makes it practical to sample status on every cycle of a command. Random commands with 0 to 20 parameters cover both checksum wrap-around and overflow. The directed cases cover commands written while busy, pushes for the next command made during execution, and overlapping activity on both channels.

// File: rtl/cmdbox_pkg.sv
package cmdbox_pkg;
    localparam int ADDR_W = 8;
    localparam int NUM_CH = 2;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic busy;
        logic res_empty;
    } chan_flags_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_CMD,
        REG_PARSTAT,
        REG_RESULT
    } reg_kind_e;

    function automatic byte_t status_byte(chan_flags_t f);
        return {f.busy, f.res_empty, 6'b000000};
    endfunction

    function automatic byte_t cmd_ofs(int ch);
        return (ch == 0) ? 8'h04 : 8'h16;
    endfunction

    function automatic byte_t ps_ofs(int ch);
        return (ch == 0) ? 8'h05 : 8'h17;
    endfunction

    function automatic byte_t res_ofs(int ch);
        return (ch == 0) ? 8'h08 : 8'h18;
    endfunction

    function automatic reg_kind_e decode(byte_t a, byte_t c_o, byte_t p_o, byte_t r_o);
        if (a == c_o) return REG_CMD;
        if (a == p_o) return REG_PARSTAT;
        if (a == r_o) return REG_RESULT;
        return REG_NONE;
    endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
    import cmdbox_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  push,
    input  byte_t din,
    input  logic  pop,
    output byte_t dout,
    output logic  empty,
    output logic  full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    byte_t              mem [DEPTH];
    logic [PTR_W-1:0]   rd_q, wr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? 8'h00 : mem[rd_q];

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= din;
                wr_q      <= nxt(wr_q);
            end
            if (do_pop) rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5: popping an empty queue leaves it empty
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
        empty && pop && !push && !clr |=> empty);
    // R3: count never passes the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop && !clr |=> full);
endmodule

// File: rtl/param_store.sv
module param_store
    import cmdbox_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      push,
    input  byte_t                     din,
    output byte_t                     sum,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    byte_t            mem  [DEPTH];
    byte_t            part [DEPTH+1];
    logic [CNT_W-1:0] cnt_q;

    assign count   = cnt_q;
    assign part[0] = 8'h00;

    for (genvar i = 0; i < DEPTH; i++) begin : g_sum
        assign part[i+1] = part[i] + ((CNT_W'(i) < cnt_q) ? mem[i] : 8'h00);
    end

    assign sum = part[DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (push && cnt_q < CNT_W'(DEPTH)) begin
            mem[cnt_q[CNT_W-2:0]] <= din;
            cnt_q                 <= cnt_q + 1'b1;
        end
    end

    // R3: a push into a full store is dropped
    p_drop_full_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q == CNT_W'(DEPTH) && push && !clr |=> cnt_q == CNT_W'(DEPTH) && $stable(sum));
endmodule

// File: rtl/cmd_channel.sv
module cmd_channel
    import cmdbox_pkg::*;
#(
    parameter int    DEPTH       = 16,
    parameter int    EXEC_CYCLES = 8,
    parameter byte_t CMD_OFS     = 8'h04,
    parameter byte_t PS_OFS      = 8'h05,
    parameter byte_t RES_OFS     = 8'h08
) (
    input  logic  clk,
    input  logic  rst,
    input  byte_t addr,
    input  logic  wr,
    input  logic  rd,
    input  byte_t wdata,
    output byte_t rdata
);
    localparam int CNT_W  = (EXEC_CYCLES > 2) ? $clog2(EXEC_CYCLES) : 1;
    localparam int PCNT_W = $clog2(DEPTH + 1);

    reg_kind_e         kind;
    logic              cmd_wr, accept, par_push, res_pop;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    byte_t             sum_q, cmd_q, psum, res_dout, res_din;
    logic              res_empty, res_full, res_push;
    logic [PCNT_W-1:0] pcount;
    chan_flags_t       flags;

    assign kind     = decode(addr, CMD_OFS, PS_OFS, RES_OFS);
    assign cmd_wr   = wr && kind == REG_CMD;
    assign accept   = cmd_wr && !busy_q;
    assign par_push = wr && kind == REG_PARSTAT;
    assign res_pop  = rd && kind == REG_RESULT;

    param_store #(.DEPTH(DEPTH)) u_params (
        .clk(clk), .rst(rst), .clr(accept), .push(par_push),
        .din(wdata), .sum(psum), .count(pcount)
    );

    // executor stub: checksum byte one cycle before the command byte
    assign res_push = busy_q && (cnt_q <= CNT_W'(1));
    assign res_din  = (cnt_q == CNT_W'(1)) ? sum_q : cmd_q;

    byte_fifo #(.DEPTH(DEPTH)) u_results (
        .clk(clk), .rst(rst), .clr(accept), .push(res_push), .din(res_din),
        .pop(res_pop), .dout(res_dout), .empty(res_empty), .full(res_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            sum_q  <= 8'h00;
            cmd_q  <= 8'h00;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(EXEC_CYCLES - 1);
            sum_q  <= psum;
            cmd_q  <= wdata;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign flags.busy      = busy_q;
    assign flags.res_empty = res_empty;

    always_comb begin
        unique case (kind)
            REG_PARSTAT: rdata = status_byte(flags);
            REG_RESULT:  rdata = res_dout;
            default:     rdata = 8'h00;
        endcase
    end

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy_q);
    p_done_result_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> !res_empty);
    p_accept_clear_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> pcount == '0 && !res_full && (res_empty || busy_q));
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q && cmd_wr |=> $stable(cmd_q) && $stable(sum_q));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import cmdbox_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int EXEC_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    byte_t ch_rdata [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cmd_channel #(
            .DEPTH(DEPTH), .EXEC_CYCLES(EXEC_CYCLES),
            .CMD_OFS(cmd_ofs(c)), .PS_OFS(ps_ofs(c)), .RES_OFS(res_ofs(c))
        ) u_chan (
            .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
            .wdata(bus_wdata), .rdata(ch_rdata[c])
        );
    end

    always_comb begin
        bus_rdata = 8'h00;
        for (int c = 0; c < NUM_CH; c++) bus_rdata = bus_rdata | ch_rdata[c];
    end

    p_status_low_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (bus_addr == 8'h05 || bus_addr == 8'h17) |-> bus_rdata[5:0] == 6'b0);
    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr > 8'h18 |-> bus_rdata == 8'h00);
endmodule

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 0, rst = 1;
    logic [7:0] bus_addr = 0, bus_wdata = 0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_rdata;
    int checks = 0, errors = 0;
    bit done = 0;

    cmd_mailbox u_cmd_mailbox (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] o_cmd(int ch); return ch ? 8'h16 : 8'h04; endfunction
    function automatic logic [7:0] o_ps(int ch);  return ch ? 8'h17 : 8'h05; endfunction
    function automatic logic [7:0] o_res(int ch); return ch ? 8'h18 : 8'h08; endfunction

    function automatic logic [7:0] exp_sum(logic [7:0] p [32], int n);
        logic [7:0] s = 0;
        for (int i = 0; i < n && i < DEPTH; i++) s = s + p[i];
        return s;
    endfunction

    task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 0;
    endtask

    // issue a command and check status on cycles 1, 8 and 9 after the write
    task automatic run_cmd(int ch, logic [7:0] cmd, logic [7:0] p [32], int n);
        for (int i = 0; i < n; i++) wr(o_ps(ch), p[i]);
        wr(o_cmd(ch), cmd);
        bus_addr = o_ps(ch);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk); #1;
            if (k == 1) chk(bus_rdata, 8'hC0, "R1 busy after command");
            if (k == 8) chk(bus_rdata, 8'h80, "R4 busy on cycle 8");
            if (k == 9) chk(bus_rdata, 8'h00, "R4 done after 8 cycles");
        end
    endtask

    task automatic get_results(int ch, logic [7:0] cmd, logic [7:0] s);
        logic [7:0] d;
        rd(o_res(ch), d); chk(d, s, "R4 checksum byte");
        rd(o_res(ch), d); chk(d, cmd, "R4 command byte");
        rd(o_res(ch), d); chk(d, 8'h00, "R5 empty read");
        rd(o_ps(ch), d);  chk(d, 8'h40, "R5 status empty after drain");
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, p [32], c, s;
        void'($urandom(32'h1d2c));
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R9 reset state and unmapped reads
        rd(8'h05, d); chk(d, 8'h40, "R9 N reset status");
        rd(8'h17, d); chk(d, 8'h40, "R9 S reset status");
        rd(8'h20, d); chk(d, 8'h00, "R9 unmapped read");
        rd(8'h18, d); chk(d, 8'h00, "R5 pop of empty queue");

        // R2 basic parameters on N
        p[0] = 8'h11; p[1] = 8'h22; p[2] = 8'h33;
        run_cmd(0, 8'h5A, p, 3);
        get_results(0, 8'h5A, 8'h66);

        // R3 overflow: 20 pushes, only 16 counted
        for (int i = 0; i < 20; i++) p[i] = 8'(8'h30 + i);
        run_cmd(1, 8'hA7, p, 20);
        get_results(1, 8'hA7, exp_sum(p, 20));

        // R7 command while busy ignored; R10-style: pushes during busy go to next
        p[0] = 8'h05;
        wr(8'h05, 8'h05);
        wr(8'h04, 8'h21);
        wr(8'h04, 8'h99);          // ignored
        wr(8'h05, 8'h07);          // lands for next command
        repeat (8) @(posedge clk);
        rd(8'h05, d); chk(d, 8'h00, "R7 no second execution");
        get_results(0, 8'h21, 8'h05);
        repeat (10) @(posedge clk);
        rd(8'h05, d); chk(d, 8'h40, "R7 still idle");
        // R6: next command sees only the byte pushed after acceptance
        run_cmd(0, 8'h3C, p, 0);
        get_results(0, 8'h3C, 8'h07);

        // R6 unread results cleared by a new command
        p[0] = 8'h01;
        run_cmd(1, 8'h10, p, 1);
        run_cmd(1, 8'h20, p, 0);
        get_results(1, 8'h20, 8'h00);

        // R8 independence: N busy, S unaffected
        wr(8'h05, 8'h09);
        wr(8'h04, 8'h44);
        rd(8'h17, d); chk(d, 8'h40, "R8 S idle while N busy");
        rd(8'h18, d); chk(d, 8'h00, "R8 S results empty");
        repeat (10) @(posedge clk);
        rd(8'h17, d); chk(d, 8'h40, "R8 S untouched after N done");
        get_results(0, 8'h44, 8'h09);

        // random commands
        for (int it = 0; it < 30; it++) begin
            int ch, n;
            ch = $urandom_range(0, 1);
            n  = $urandom_range(0, 20);
            for (int i = 0; i < n; i++) p[i] = 8'($urandom);
            c = 8'($urandom);
            s = exp_sum(p, n);
            run_cmd(ch, c, p, n);
            get_results(ch, c, s);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule